// File: doc/BRIEF.md
# Cascaded multi-bus priority picker

This block decides, in a single cycle, which function units get one of several shared buses. Every function unit drives one bit of a request vector. A chain of picking stages, one stage per bus, produces one grant vector per bus. Each grant vector has one bit per unit and at most one bit set. Stage 0 takes the raw request vector and grants the highest-priority requester. Every later stage sees only the requests that earlier stages left ungranted, so each bus in a cycle goes to a different unit.

Each stage is a priority encoder feeding a decoder, which turns the winning index back into a one-hot grant. The lowest unit index has the highest priority. The number of units and the number of buses are parameters. A mode parameter selects one of two outputs: the combinational result, or that result held in one register stage. The register stage clears under the active-low asynchronous reset.

Top module: `multi_bus_picker`

## Requirements
- R1: Bit `b*NUM_UNITS + i` of `grant_o` is unit i's grant on bus b. Bus 0 grants the lowest-index unit whose `req_i` bit is set.
- R2: Bus b (b > 0) grants the unit holding the (b+1)-th lowest set bit of `req_i`, which is the lowest request not granted by buses 0 to b-1.
- R3: No unit is granted on more than one bus in a cycle, and no unit without a request is granted.
- R4: A bus with no remaining request has an all-zero grant and `valid_o[b]` = 0. Otherwise `valid_o[b]` = 1 and its grant is one-hot.
- R5: With `OUT_MODE = OUT_REG`, grants and valid flags update on the rising clock edge that samples `req_i`. While `rst_ni` is low they are all zero.
- R6: With `OUT_MODE = OUT_COMB`, grants and valid flags follow `req_i` in the same cycle, with no clock edge.
- R7: The number of set `valid_o` bits equals the smaller of the popcount of the requests and `NUM_BUSES`.
- R8: Buses fill in index order: `valid_o[b]` implies `valid_o[b-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_UNITS | One request bit per function unit |
| grant_o | output | NUM_BUSES*NUM_UNITS | One one-hot grant vector per bus, bus b at bits [b*NUM_UNITS +: NUM_UNITS] |
| valid_o | output | NUM_BUSES | Bus b has a granted unit |

## Verification
In combinational mode every grant and valid flag is due in the same cycle a request pattern is applied. The bench drives each pattern at the falling edge and checks that instance one time step later. In registered mode the same results are due after the next rising edge. The bench checks them one time step after that edge, and before the following falling edge changes the request. Reset is checked while requests are active: before the first edge, and again during an asynchronous reset in the middle of the run.

// File: rtl/picker_pkg.sv
package picker_pkg;
  typedef enum bit {OUT_COMB = 1'b0, OUT_REG = 1'b1} out_mode_e;
  localparam int unsigned DEF_UNITS = 8;
  localparam int unsigned DEF_BUSES = 3;
endpackage

// File: rtl/prio_enc.sv
module prio_enc #(
  parameter int unsigned W  = 8,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          found_o
);
  // scan downward so the lowest set bit is written last and wins
  always_comb begin
    idx_o   = '0;
    found_o = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o   = IW'(i);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/idx_dec.sv
module idx_dec #(
  parameter int unsigned W  = 8,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [IW-1:0] idx_i,
  input  logic          en_i,
  output logic [W-1:0]  onehot_o
);
  always_comb begin
    onehot_o = '0;
    for (int i = 0; i < W; i++) begin
      if (en_i && (idx_i == IW'(i))) onehot_o[i] = 1'b1;
    end
  end
endmodule

// File: rtl/pick_stage.sv
module pick_stage #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] avail_i,
  output logic [W-1:0] grant_o,
  output logic         valid_o,
  output logic [W-1:0] rest_o
);
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1;

  logic [IW-1:0] win_idx;
  logic          win_found;

  prio_enc #(.W(W)) u_enc (
    .vec_i   (avail_i),
    .idx_o   (win_idx),
    .found_o (win_found)
  );

  idx_dec #(.W(W)) u_dec (
    .idx_i    (win_idx),
    .en_i     (win_found),
    .onehot_o (grant_o)
  );

  assign valid_o = win_found;
  assign rest_o  = avail_i & ~grant_o;
endmodule

// File: rtl/multi_bus_picker.sv
module multi_bus_picker
  import picker_pkg::*;
#(
  parameter int unsigned NUM_UNITS = DEF_UNITS,
  parameter int unsigned NUM_BUSES = DEF_BUSES,
  parameter out_mode_e   OUT_MODE  = OUT_REG
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_UNITS-1:0]           req_i,
  output logic [NUM_BUSES*NUM_UNITS-1:0] grant_o,
  output logic [NUM_BUSES-1:0]           valid_o
);
  localparam int unsigned GW = NUM_BUSES * NUM_UNITS;

  logic [NUM_UNITS-1:0] avail [NUM_BUSES+1];
  logic [GW-1:0]        grant_c;
  logic [NUM_BUSES-1:0] valid_c;

  assign avail[0] = req_i;

  for (genvar b = 0; b < NUM_BUSES; b++) begin : g_stage
    pick_stage #(.W(NUM_UNITS)) u_stage (
      .avail_i (avail[b]),
      .grant_o (grant_c[b*NUM_UNITS +: NUM_UNITS]),
      .valid_o (valid_c[b]),
      .rest_o  (avail[b+1])
    );
  end

  if (OUT_MODE == OUT_REG) begin : g_reg
    logic [GW-1:0]        grant_q;
    logic [NUM_BUSES-1:0] valid_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        grant_q <= '0;
        valid_q <= '0;
      end else begin
        grant_q <= grant_c;
        valid_q <= valid_c;
      end
    end
    assign grant_o = grant_q;
    assign valid_o = valid_q;
  end else begin : g_comb
    assign grant_o = grant_c;
    assign valid_o = valid_c;
  end
endmodule

// File: rtl/multi_bus_picker_chk.sv
module multi_bus_picker_chk #(
  parameter int unsigned NU      = 8,
  parameter int unsigned NB      = 3,
  parameter bit          REG_OUT = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NU-1:0]    req_i,
  input logic [NB*NU-1:0] grant_o,
  input logic [NB-1:0]    valid_o
);
  logic [NU-1:0] req_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      req_q  <= req_i;
      seen_q <= 1'b1;
    end
  end

  logic [NU-1:0] ref_req;
  logic          ref_ok;
  logic [NU-1:0] gunion;
  logic          overlap;
  int            exp_nv;

  assign ref_req = REG_OUT ? req_q : req_i;
  assign ref_ok  = REG_OUT ? seen_q : 1'b1;

  always_comb begin
    gunion  = '0;
    overlap = 1'b0;
    for (int b = 0; b < int'(NB); b++) begin
      if ((gunion & grant_o[b*NU +: NU]) != '0) overlap = 1'b1;
      gunion = gunion | grant_o[b*NU +: NU];
    end
    exp_nv = ($countones(ref_req) < int'(NB)) ? $countones(ref_req) : int'(NB);
  end

  // R3
  no_dup_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !overlap);

  // R3
  grant_in_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ok |-> ((gunion & ~ref_req) == '0));

  // R7
  valid_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ok |-> ($countones(valid_o) == exp_nv));

  // R1
  bus0_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_ok && valid_o[0]) |->
      (((grant_o[NU-1:0] - NU'(1)) & ref_req) == '0));

  for (genvar b = 0; b < NB; b++) begin : g_bus
    // R4
    grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(grant_o[b*NU +: NU]));
    // R4
    valid_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o[b] == (grant_o[b*NU +: NU] != '0));
    if (b > 0) begin : g_ord
      // R8
      fill_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o[b] |-> valid_o[b-1]);
    end
  end
endmodule

bind multi_bus_picker multi_bus_picker_chk #(
  .NU      (NUM_UNITS),
  .NB      (NUM_BUSES),
  .REG_OUT (OUT_MODE == picker_pkg::OUT_REG)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .grant_o (grant_o),
  .valid_o (valid_o)
);

// File: tb/multi_bus_picker_test.sv
`timescale 1ns/1ps
module multi_bus_picker_test;
  localparam int NU = 8;
  localparam int NB = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NU-1:0] req = '0;
  logic [NB*NU-1:0] grant_r, grant_c;
  logic [NB-1:0]    valid_r, valid_c;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  multi_bus_picker #(.NUM_UNITS(NU), .NUM_BUSES(NB),
                     .OUT_MODE(picker_pkg::OUT_REG)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req),
    .grant_o(grant_r), .valid_o(valid_r));

  multi_bus_picker #(.NUM_UNITS(NU), .NUM_BUSES(NB),
                     .OUT_MODE(picker_pkg::OUT_COMB)) uut_comb (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req),
    .grant_o(grant_c), .valid_o(valid_c));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // b-th lowest set bit of r as one-hot, zero if fewer requests
  function automatic logic [NU-1:0] exp_grant(logic [NU-1:0] r, int b);
    logic [NU-1:0] e = '0;
    int n = 0;
    for (int i = 0; i < NU; i++) begin
      if (r[i]) begin
        if (n == b) e[i] = 1'b1;
        n++;
      end
    end
    return e;
  endfunction

  task automatic check_all(string mode, logic [NU-1:0] r,
                           logic [NB*NU-1:0] g, logic [NB-1:0] v);
    logic [NU-1:0] uni = '0;
    int nv = 0;
    int ev;
    for (int b = 0; b < NB; b++) begin
      logic [NU-1:0] e = exp_grant(r, b);
      string t = (b == 0) ? "R1" : "R2";
      chk($sformatf("%s %s bus%0d grant req=%h", t, mode, b, r),
          32'(g[b*NU +: NU]), 32'(e));
      chk($sformatf("R4 %s bus%0d valid req=%h", mode, b, r),
          32'(v[b]), 32'(e != '0));
      if ((uni & g[b*NU +: NU]) != '0)
        chk($sformatf("R3 %s overlap bus%0d", mode, b), 32'(1), 32'(0));
      uni = uni | g[b*NU +: NU];
      nv += int'(v[b]);
    end
    chk($sformatf("R3 %s grants within req=%h", mode, r), 32'(uni & ~r), 32'(0));
    ev = ($countones(r) < NB) ? $countones(r) : NB;
    chk($sformatf("R7 %s valid count req=%h", mode, r), 32'(nv), 32'(ev));
    chk($sformatf("R8 %s fill order req=%h", mode, r), 32'(v),
        32'((1 << ev) - 1));
  endtask

  initial begin
    req = 8'hA5;
    #1;
    chk("R5 reset grant", 32'(grant_r), 32'(0));
    chk("R5 reset valid", 32'(valid_r), 32'(0));
    @(posedge clk); #1;
    chk("R5 reset held grant", 32'(grant_r), 32'(0));
    @(negedge clk); rst_ni = 1'b1;

    for (int p = 0; p < (1 << NU); p++) begin
      @(negedge clk);
      req = NU'(p);
      #1;
      // R6: combinational instance settles in the same cycle
      check_all("R6 comb", req, grant_c, valid_c);
      // R5: registered instance still shows the previous pattern
      if (p > 0)
        chk("R5 reg holds until edge", 32'(grant_r[NU-1:0]),
            32'(exp_grant(NU'(p - 1), 0)));
      @(posedge clk); #1;
      check_all("R5 reg", req, grant_r, valid_r);
    end

    @(negedge clk); req = 8'hFF;
    @(posedge clk); #1;
    #1 rst_ni = 1'b0;
    #1;
    chk("R5 async reset grant", 32'(grant_r), 32'(0));
    chk("R5 async reset valid", 32'(valid_r), 32'(0));
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    check_all("R5 after reset", req, grant_r, valid_r);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule